// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two table entries from memory, one at a time. The address is cut into a 12-bit index into the outer table, a 10-bit index into an inner table, and a 10-bit byte offset inside a 1 KB page. The outer table begins at an address held in a base register. A length register limits how many outer entries may be used. Both registers are loaded through their own write ports.

A client offers one translation at a time, with an access type of read or write. The walker lowers its ready output while it works. It reads words over a request/response memory port. It then gives a one-cycle result pulse that carries either a physical address or a 2-bit fault code. A fault ends the walk at once, and no further reads are issued.

Each table entry is one 32-bit word. Bit 0 of the entry is the valid flag. Bit 1 is the writable flag, and it is checked only in the leaf entry. Bits 31:10 give the base of the next table or of the page frame, and that base is aligned to 1 KB.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is ready, the result and memory-request outputs are low, and the base and length registers hold 0, so every request gets the length fault.
- R2: The virtual address splits into an outer index (bits 31:20), an inner index (bits 19:10) and an offset (bits 9:0). The first read goes to base + 4 × outer index.
- R3: The second read goes to {outer entry bits 31:10, 10'b0} + 4 × inner index.
- R4: An outer index at or above the length register (a 13-bit count, so 4096 admits index 4095) gives fault code 01 with no memory read. The result pulse comes in the cycle right after the request is accepted.
- R5: An outer entry whose bit 0 is clear gives fault code 10 after exactly one read.
- R6: A leaf entry whose bit 0 is clear gives fault code 10 for both reads and writes.
- R7: A write to a leaf whose bit 1 is clear gives fault code 11. A read of the same page succeeds.
- R8: A successful walk returns fault 00 and physical address {leaf bits 31:10, offset}. Any fault returns physical address 0.
- R9: Bit 1 of the outer entry has no effect: a write through an outer entry with bit 1 clear still succeeds.
- R10: Only one walk runs at a time. The ready output is low from the cycle after acceptance until the result pulse. The pulse lasts one cycle, and ready is high again in the next cycle.
- R11: A memory request that is not yet accepted keeps its valid signal and its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_valid | input | 1 | Translation request offered |
| tr_ready | output | 1 | Walker idle, request accepted when both high |
| tr_vaddr | input | 32 | Virtual address to translate |
| tr_write | input | 1 | 1 = write access, 0 = read access |
| base_we | input | 1 | Load the outer-table base register |
| base_wdata | input | 32 | New outer-table base |
| len_we | input | 1 | Load the length register |
| len_wdata | input | 13 | Number of usable outer entries |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table entry |
| res_valid | output | 1 | One-cycle result pulse |
| res_paddr | output | 32 | Physical address, 0 on a fault |
| res_fault | output | 2 | 00 none, 01 length, 10 invalid, 11 protection |

## Verification
The properties rest on three assumptions about the inputs. The memory returns a response only for a request it has accepted, and only one response for each. The base and length registers are not rewritten while a walk is in flight. A new request is not offered while the walker is busy. The bench memory model answers exactly one cycle after each accepted read, and it throttles the request ready in a fixed pattern. The driver writes registers and offers requests only while the walker is idle, and waits for each result before it starts the next walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // Entry flag positions
    localparam int unsigned PTE_VALID_BIT = 0;
    localparam int unsigned PTE_WRITE_BIT = 1;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_LEN     = 2'b01,
        FLT_INVALID = 2'b10,
        FLT_PROT    = 2'b11
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUT_REQ,
        ST_OUT_WAIT,
        ST_IN_REQ,
        ST_IN_WAIT,
        ST_DONE
    } walk_state_e;

endpackage

// File: rtl/ptw_vaddr_split.sv
module ptw_vaddr_split #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OUT_IDX_W = 12,
    parameter int unsigned IN_IDX_W  = 10,
    localparam int unsigned OFF_W    = ADDR_W - OUT_IDX_W - IN_IDX_W
) (
    input  logic [ADDR_W-1:0]    vaddr,
    output logic [OUT_IDX_W-1:0] outer_idx,
    output logic [IN_IDX_W-1:0]  inner_idx,
    output logic [OFF_W-1:0]     offset
);
    assign outer_idx = vaddr[ADDR_W-1 -: OUT_IDX_W];
    assign inner_idx = vaddr[OFF_W +: IN_IDX_W];
    assign offset    = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 12
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int unsigned PAD_W = ADDR_W - IDX_W - 2;

    // Word-sized entries: scale the index by four
    assign entry_addr = table_base + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import pt_walker_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 10
) (
    input  logic [ADDR_W-1:0] pte,
    output logic              valid,
    output logic              writable,
    output logic [ADDR_W-1:0] next_base
);
    logic unused_pte_bits;

    assign valid           = pte[PTE_VALID_BIT];
    assign writable        = pte[PTE_WRITE_BIT];
    assign next_base       = {pte[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign unused_pte_bits = ^pte[OFF_W-1:2];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OUT_IDX_W = 12,
    parameter int unsigned IN_IDX_W  = 10,
    localparam int unsigned OFF_W    = ADDR_W - OUT_IDX_W - IN_IDX_W,
    localparam int unsigned LEN_W    = OUT_IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tr_valid,
    output logic              tr_ready,
    input  logic [ADDR_W-1:0] tr_vaddr,
    input  logic              tr_write,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_paddr,
    output logic [1:0]        res_fault
);

    typedef struct packed {
        walk_state_e       state;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] vaddr;
        logic              write;
        logic [ADDR_W-1:0] inner_base;
        logic [ADDR_W-1:0] paddr;
        fault_e            fault;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [OUT_IDX_W-1:0] outer_idx;
    logic [IN_IDX_W-1:0]  inner_idx;
    logic [OFF_W-1:0]     offset;
    logic [ADDR_W-1:0]    outer_addr;
    logic [ADDR_W-1:0]    inner_addr;
    logic                 pte_valid;
    logic                 pte_writable;
    logic [ADDR_W-1:0]    pte_base;
    logic [LEN_W-1:0]     req_outer_ext;

    // Exposed for the bound checker
    logic [LEN_W-1:0]     len_cur;
    logic [ADDR_W-1:0]    vaddr_cur;

    ptw_vaddr_split #(
        .ADDR_W    (ADDR_W),
        .OUT_IDX_W (OUT_IDX_W),
        .IN_IDX_W  (IN_IDX_W)
    ) u_split (
        .vaddr     (r_q.vaddr),
        .outer_idx (outer_idx),
        .inner_idx (inner_idx),
        .offset    (offset)
    );

    ptw_entry_addr #(
        .ADDR_W (ADDR_W),
        .IDX_W  (OUT_IDX_W)
    ) u_outer_addr (
        .table_base (r_q.base),
        .idx        (outer_idx),
        .entry_addr (outer_addr)
    );

    ptw_entry_addr #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IN_IDX_W)
    ) u_inner_addr (
        .table_base (r_q.inner_base),
        .idx        (inner_idx),
        .entry_addr (inner_addr)
    );

    ptw_pte_decode #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_pte (
        .pte       (mem_rsp_data),
        .valid     (pte_valid),
        .writable  (pte_writable),
        .next_base (pte_base)
    );

    assign req_outer_ext = {1'b0, tr_vaddr[ADDR_W-1 -: OUT_IDX_W]};

    always_comb begin
        r_d = r_q;

        if (base_we) r_d.base = base_wdata;
        if (len_we)  r_d.len  = len_wdata;

        unique case (r_q.state)
            ST_IDLE: begin
                if (tr_valid) begin
                    r_d.vaddr = tr_vaddr;
                    r_d.write = tr_write;
                    r_d.paddr = '0;
                    if (req_outer_ext >= r_q.len) begin
                        r_d.fault = FLT_LEN;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.fault = FLT_NONE;
                        r_d.state = ST_OUT_REQ;
                    end
                end
            end
            ST_OUT_REQ: begin
                if (mem_req_ready) r_d.state = ST_OUT_WAIT;
            end
            ST_OUT_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_valid) begin
                        r_d.fault = FLT_INVALID;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.inner_base = pte_base;
                        r_d.state      = ST_IN_REQ;
                    end
                end
            end
            ST_IN_REQ: begin
                if (mem_req_ready) r_d.state = ST_IN_WAIT;
            end
            ST_IN_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.state = ST_DONE;
                    if (!pte_valid) begin
                        r_d.fault = FLT_INVALID;
                    end else if (r_q.write && !pte_writable) begin
                        r_d.fault = FLT_PROT;
                    end else begin
                        r_d.fault = FLT_NONE;
                        r_d.paddr = {pte_base[ADDR_W-1:OFF_W], offset};
                    end
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{
                state:      ST_IDLE,
                base:       '0,
                len:        '0,
                vaddr:      '0,
                write:      1'b0,
                inner_base: '0,
                paddr:      '0,
                fault:      FLT_NONE
            };
        end else begin
            r_q <= r_d;
        end
    end

    assign tr_ready      = (r_q.state == ST_IDLE);
    assign mem_req_valid = (r_q.state == ST_OUT_REQ) || (r_q.state == ST_IN_REQ);
    assign mem_req_addr  = (r_q.state == ST_IN_REQ) ? inner_addr : outer_addr;
    assign res_valid     = (r_q.state == ST_DONE);
    assign res_paddr     = r_q.paddr;
    assign res_fault     = r_q.fault;
    assign len_cur       = r_q.len;
    assign vaddr_cur     = r_q.vaddr;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OUT_IDX_W = 12,
    parameter int unsigned OFF_W     = 10,
    localparam int unsigned LEN_W    = OUT_IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tr_valid,
    input logic              tr_ready,
    input logic [ADDR_W-1:0] tr_vaddr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_paddr,
    input logic [1:0]        res_fault,
    input logic [LEN_W-1:0]  len_cur,
    input logic [ADDR_W-1:0] vaddr_cur
);
    logic [LEN_W-1:0] req_ext;
    logic             unused_chk;

    assign req_ext    = {1'b0, tr_vaddr[ADDR_W-1 -: OUT_IDX_W]};
    assign unused_chk = ^{tr_vaddr[ADDR_W-OUT_IDX_W-1:0], vaddr_cur[ADDR_W-1:OFF_W]};

    // R10: busy right after acceptance
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_ready) |=> !tr_ready);

    // R10: single-cycle result pulse, then idle
    p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && tr_ready));

    // R10: an idle walker neither reads nor reports
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tr_ready |-> (!mem_req_valid && !res_valid));

    // R11: pending request is held
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: length fault in the next cycle
    p_len_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_ready && (req_ext >= len_cur)) |=> (res_valid && res_fault == 2'b01));

    // R8: offset carried through on success
    p_offset_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'b00) |-> (res_paddr[OFF_W-1:0] == vaddr_cur[OFF_W-1:0]));

    // R8: faulted results carry address zero
    p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 2'b00) |-> (res_paddr == '0));

endmodule

bind pt_walker pt_walker_chk #(
    .ADDR_W    (ADDR_W),
    .OUT_IDX_W (OUT_IDX_W),
    .OFF_W     (OFF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tr_valid      (tr_valid),
    .tr_ready      (tr_ready),
    .tr_vaddr      (tr_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_fault     (res_fault),
    .len_cur       (len_cur),
    .vaddr_cur     (vaddr_cur)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tr_valid = 1'b0;
    logic        tr_ready;
    logic [31:0] tr_vaddr = '0;
    logic        tr_write = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        len_we = 1'b0;
    logic [12:0] len_wdata = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic [1:0]  res_fault;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    int unsigned cyc    = 0;

    logic [31:0] mem [bit [31:0]];
    logic [33:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] rd_q  [$];
    logic [31:0] m_base = '0;
    logic [12:0] m_len  = '0;

    pt_walker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tr_valid      (tr_valid),
        .tr_ready      (tr_ready),
        .tr_vaddr      (tr_vaddr),
        .tr_write      (tr_write),
        .base_we       (base_we),
        .base_wdata    (base_wdata),
        .len_we        (len_we),
        .len_wdata     (len_wdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_paddr     (res_paddr),
        .res_fault     (res_fault)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: ready pattern and one-cycle response
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 2;
        mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready;
        mem_rsp_data  <= rdm(mem_req_addr);
    end

    // Read address monitor (R2, R3, R4, R5)
    always @(negedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (rd_q.size() == 0) begin
                check(1'b0, "R4 R5 unexpected read", {32'h0, mem_req_addr}, 64'h0);
            end else begin
                logic [31:0] ea;
                ea = rd_q.pop_front();
                check(mem_req_addr == ea, "R2 R3 read address", {32'h0, mem_req_addr}, {32'h0, ea});
            end
        end
    end

    // Result scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", {30'h0, res_fault, res_paddr}, 64'h0);
            end else begin
                logic [33:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({res_fault, res_paddr} == e, t, {30'h0, res_fault, res_paddr}, {30'h0, e});
                check(rd_q.size() == 0, "R4 R5 read count", 64'(rd_q.size()), 64'h0);
            end
        end
    end

    task automatic set_regs(input logic [31:0] b, input logic [12:0] l);
        @(negedge clk);
        base_we = 1'b1; base_wdata = b;
        len_we  = 1'b1; len_wdata  = l;
        @(negedge clk);
        base_we = 1'b0; len_we = 1'b0;
        m_base = b; m_len = l;
    endtask

    // Driver: computes the expected outcome, pushes it, runs the walk
    task automatic walk(input logic [11:0] p1, input logic [9:0] p2, input logic [9:0] off,
                        input bit wr, input string tag);
        logic [31:0] va, a1, a2, e1, e2;
        logic [33:0] ex;
        bit len_flt;
        va = {p1, p2, off};
        len_flt = ({1'b0, p1} >= m_len);
        if (len_flt) begin
            ex = {2'b01, 32'h0};
        end else begin
            a1 = m_base + {18'h0, p1, 2'b00};
            rd_q.push_back(a1);
            e1 = rdm(a1);
            if (!e1[0]) begin
                ex = {2'b10, 32'h0};
            end else begin
                a2 = {e1[31:10], 10'h0} + {20'h0, p2, 2'b00};
                rd_q.push_back(a2);
                e2 = rdm(a2);
                if (!e2[0])             ex = {2'b10, 32'h0};
                else if (wr && !e2[1])  ex = {2'b11, 32'h0};
                else                    ex = {2'b00, e2[31:10], off};
            end
        end
        exp_q.push_back(ex);
        tag_q.push_back(tag);
        @(negedge clk);
        while (!tr_ready) @(negedge clk);
        tr_valid = 1'b1; tr_vaddr = va; tr_write = wr;
        @(negedge clk);
        tr_valid = 1'b0;
        check(!tr_ready, "R10 busy after accept", {63'h0, tr_ready}, 64'h0);
        if (len_flt) check(res_valid, "R4 result next cycle", {63'h0, res_valid}, 64'h1);
        while (!res_valid) @(negedge clk);
        @(negedge clk);
        check(!res_valid && tr_ready, "R10 pulse then ready", {62'h0, res_valid, tr_ready}, 64'h1);
    endtask

    initial begin
        // Tables
        mem[32'h0001_0000] = 32'h0002_0003;   // outer 0: valid, writable
        mem[32'h0001_0004] = 32'h0003_0001;   // outer 1: valid, outer write bit clear
        mem[32'h0001_0008] = 32'h0004_0002;   // outer 2: invalid
        mem[32'h0001_001C] = 32'h0005_0001;   // outer 7: valid
        mem[32'h0002_0014] = 32'h1234_5403;   // leaf rw
        mem[32'h0002_0018] = 32'h0ABC_DC01;   // leaf read-only
        mem[32'h0002_001C] = 32'h0FFF_FC02;   // leaf invalid
        mem[32'h0003_0000] = 32'h7700_0403;   // leaf rw under outer 1
        mem[32'h0005_0FFC] = 32'h3333_3003;   // leaf at inner index 1023
        for (int k = 8; k < 40; k++) begin
            logic [31:0] lf;
            lf = (32'(k) * 32'h9E37_79B9) & 32'hFFFF_FC00;
            lf[0] = (k % 5) != 4;
            lf[1] = (k % 3) != 0;
            mem[32'h0002_0000 + 32'(k) * 4] = lf;
        end

        repeat (3) @(negedge clk);
        // R1: reset state
        check(tr_ready && !res_valid && !mem_req_valid, "R1 reset outputs",
              {61'h0, tr_ready, res_valid, mem_req_valid}, 64'h4);
        rst_n = 1'b1;

        // R1 / R4: reset length of 0 faults every request
        walk(12'h000, 10'h005, 10'h000, 1'b0, "R1 reset length fault");

        set_regs(32'h0001_0000, 13'd8);
        walk(12'h000, 10'h005, 10'h155, 1'b0, "R8 read translation");
        walk(12'h000, 10'h005, 10'h2AA, 1'b1, "R8 write translation");
        walk(12'h000, 10'h006, 10'h011, 1'b0, "R7 read of read-only page");
        walk(12'h000, 10'h006, 10'h011, 1'b1, "R7 write to read-only page");
        walk(12'h000, 10'h007, 10'h3FF, 1'b0, "R6 invalid leaf read");
        walk(12'h000, 10'h007, 10'h000, 1'b1, "R6 invalid leaf write");
        walk(12'h002, 10'h001, 10'h001, 1'b0, "R5 invalid outer entry");
        walk(12'h001, 10'h000, 10'h0F0, 1'b1, "R9 outer write bit ignored");
        walk(12'h008, 10'h000, 10'h000, 1'b0, "R4 index equal to length");
        walk(12'hFFF, 10'h3FF, 10'h3FF, 1'b1, "R4 top index");
        walk(12'h007, 10'h3FF, 10'h123, 1'b1, "R2 R3 last allowed index");

        // R4: full length admits index 4095, moved base (R2)
        set_regs(32'h0010_0000, 13'd4096);
        mem[32'h0010_3FFC] = 32'h0002_0001;
        walk(12'hFFF, 10'h005, 10'h077, 1'b0, "R4 full length boundary");
        walk(12'hFFE, 10'h005, 10'h077, 1'b0, "R5 missing outer entry");

        // Mixed pattern through the first table
        set_regs(32'h0001_0000, 13'd3);
        for (int k = 8; k < 40; k++) begin
            walk(12'h000, 10'(k), 10'(k * 13), k[0], "R6 R7 R8 mixed walks");
        end
        walk(12'h003, 10'h000, 10'h000, 1'b0, "R4 shrunk length");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 results outstanding", 64'(exp_q.size()), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule